// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time as eight packed-BCD counters: seconds, minutes, hours (24-hour), day of week, date, month, year and a century count. A free-running enable pulse from an oscillator domain, nominally 32768 pulses per second, is divided down inside the block. The divider produces a one-second advance and a faster test tick. A carry ripples from seconds through to the century. Month lengths and leap years are resolved from the current month and year, so no software correction is needed.

Two control bits travel inside the time bytes. A halt bit in the seconds byte freezes the divider and all counters. A test bit in the day byte replaces the seconds least significant bit with a square wave at the test frequency while counting continues underneath. A single load strobe writes all eight bytes at once and restarts the divider. The surrounding chip uses it to set the clock, and it reads the time back from one 64-bit bus.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, cur_time reads 64'h0000010101000000: year, century, hours, minutes and seconds are 00; day, date and month are 01; the halt and test bits are 0.
- R2: While running, the seconds count advances by exactly one on the OSC_HZ-th osc_tick pulse counted from reset or from the last load. Cycles with osc_tick low do not count.
- R3: Seconds and minutes wrap from 59 to 00, and each wrap advances the next field. Hours wrap from 23 to 00, and that wrap advances the day of week and the date together.
- R4: The day of week (byte 3, bits 2:0) counts 1 to 7 and wraps from 7 to 1 at midnight, regardless of the date value.
- R5: The date wraps to 01 and advances the month after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02 the date wraps after 29 when the year count is divisible by 4 (00 included), and after 28 otherwise.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century. Century 39 wraps to 00.
- R8: Bit 7 of the seconds byte is the halt bit. While it reads 1, no counter changes and cur_time holds steady.
- R9: Bit 6 of the day byte is the test bit. While it is 1 and the halt bit is 0, bit 0 of the seconds byte shows a phase that starts at 0 on load and flips every OSC_HZ/(2*TEST_HZ) osc_tick pulses. The seconds count itself keeps advancing.
- R10: A cycle with load high writes every byte of ld_time into the counters and control bits, and restarts the divider. Load takes priority over any advance in the same cycle.
- R11: Bits with no meaning always read 0, even when they were 1 in ld_time. These are seconds none, minutes bit 7, hours bits 7:6, day bits 7 and 5:3, date bits 7:6, month bits 7:5 and century bits 7:6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One pulse per oscillator period (OSC_HZ per second) |
| load | input | 1 | Write all bytes from ld_time this cycle |
| ld_time | input | 64 | Load value: bytes 0..7 are seconds, minutes, hours, day, date, month, year, century |
| cur_time | output | 64 | Current time in the same byte layout, with halt and test bits |

## Verification
The bench builds the block with OSC_HZ=64 and TEST_HZ=8, so a second takes 64 cycles and the test phase flips every 4 cycles. At that rate, month, year and century rollovers are reached by loading a time one second short of the boundary and waiting a single second. The short test period lets the bench watch several phase flips and a counted second within a few dozen cycles. The same counters are elaborated with OSC_HZ=32768 in the default build.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int NUM_FIELDS = 8;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DOW  = 3;
   localparam int F_DATE = 4;
   localparam int F_MON  = 5;
   localparam int F_YEAR = 6;
   localparam int F_CEN  = 7;

   localparam int HALT_BIT = 7;   // within seconds byte
   localparam int TEST_BIT = 6;   // within day-of-week byte

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic leap_year(input logic [7:0] yr);
      if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int OSC_HZ = 32768,
   parameter int TDIV   = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic sec_tick,
   output logic test_tick
);
   localparam int SW = (OSC_HZ > 1) ? $clog2(OSC_HZ) : 1;
   localparam int TW = (TDIV > 1) ? $clog2(TDIV) : 1;

   logic [SW-1:0] sec_cnt;
   logic [TW-1:0] tst_cnt;

   assign sec_tick  = en && (sec_cnt == SW'(OSC_HZ - 1));
   assign test_tick = en && (tst_cnt == TW'(TDIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sec_cnt <= '0;
         tst_cnt <= '0;
      end else if (en) begin
         sec_cnt <= sec_tick  ? '0 : sec_cnt + 1'b1;
         tst_cnt <= test_tick ? '0 : tst_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_cal_pkg::*;
#(
   parameter logic [7:0] MIN_VAL = 8'h00,
   parameter logic [7:0] MASK    = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] ld_val,
   input  logic       inc,
   input  logic [7:0] max_val,
   output logic [7:0] q,
   output logic       at_max
);
   assign at_max = (q >= max_val);

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= MIN_VAL;
      else if (load)    q <= ld_val & MASK;
      else if (inc)     q <= at_max ? MIN_VAL : bcd_inc(q);
   end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import rtc_cal_pkg::*;
#(
   parameter int OSC_HZ  = 32768,
   parameter int TEST_HZ = 512
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        osc_tick,
   input  logic        load,
   input  logic [63:0] ld_time,
   output logic [63:0] cur_time
);
   localparam int TDIV = (TEST_HZ > 0) ? OSC_HZ / (2 * TEST_HZ) : 1;

   localparam logic [NUM_FIELDS-1:0][7:0] FMASK =
      {8'h3F, 8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F};
   localparam logic [NUM_FIELDS-1:0][7:0] FMIN =
      {8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   generate
      if (TEST_HZ < 1 || OSC_HZ < 2 * TEST_HZ) begin : g_bad_rate
         $error("bcd_calendar: TEST_HZ must be positive and at most OSC_HZ/2");
      end
      if ((OSC_HZ % (2 * TEST_HZ)) != 0) begin : g_bad_div
         $error("bcd_calendar: OSC_HZ must be a multiple of 2*TEST_HZ");
      end
   endgenerate

   logic [NUM_FIELDS-1:0][7:0] field_q;
   logic [NUM_FIELDS-1:0][7:0] max_v;
   logic [NUM_FIELDS-1:0]      at_max;
   logic [NUM_FIELDS-1:0]      inc_v;
   logic stop_q, test_q, phase_q;
   logic sec_tick, test_tick;
   logic tick_min, tick_hour, tick_day, tick_mon, tick_year, tick_cen;

   rtc_prescaler #(.OSC_HZ(OSC_HZ), .TDIV(TDIV)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(load || stop_q),
      .en(osc_tick && !stop_q),
      .sec_tick(sec_tick), .test_tick(test_tick)
   );

   // ripple of carries; day of week and date both advance on the hour wrap
   always_comb begin
      tick_min  = sec_tick  && at_max[F_SEC];
      tick_hour = tick_min  && at_max[F_MIN];
      tick_day  = tick_hour && at_max[F_HOUR];
      tick_mon  = tick_day  && at_max[F_DATE];
      tick_year = tick_mon  && at_max[F_MON];
      tick_cen  = tick_year && at_max[F_YEAR];
      inc_v = {tick_cen, tick_year, tick_mon, tick_day, tick_day,
               tick_hour, tick_min, sec_tick};
      max_v = {8'h39, 8'h99, 8'h12, last_day(field_q[F_MON], field_q[F_YEAR]),
               8'h07, 8'h23, 8'h59, 8'h59};
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
         rtc_bcd_field #(.MIN_VAL(FMIN[gi]), .MASK(FMASK[gi])) u_fld (
            .clk(clk), .rst_n(rst_n), .load(load),
            .ld_val(ld_time[gi*8 +: 8]), .inc(inc_v[gi]),
            .max_val(max_v[gi]), .q(field_q[gi]), .at_max(at_max[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         test_q <= 1'b0;
      end else if (load) begin
         stop_q <= ld_time[F_SEC*8 + HALT_BIT];
         test_q <= ld_time[F_DOW*8 + TEST_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || load || !test_q || stop_q) phase_q <= 1'b0;
      else if (test_tick)                      phase_q <= ~phase_q;
   end

   always_comb begin
      cur_time = field_q;
      cur_time[F_SEC*8 + HALT_BIT] = stop_q;
      cur_time[F_DOW*8 + TEST_BIT] = test_q;
      if (test_q && !stop_q) cur_time[F_SEC*8] = phase_q;
   end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        load,
   input logic        osc_tick,
   input logic        sec_tick,
   input logic        stop_bit,
   input logic [63:0] field_q,
   input logic [63:0] cur_time
);
   localparam logic [63:0] USED = 64'h3FFF1F3F47_3F7FFF;

   assert_sec_min_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      field_q[7:0] <= 8'h59 && field_q[15:8] <= 8'h59);
   assert_hour_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      field_q[23:16] <= 8'h23);
   assert_dow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      field_q[31:24] >= 8'h01 && field_q[31:24] <= 8'h07);
   assert_date_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      field_q[39:32] >= 8'h01 && field_q[39:32] <= 8'h31);
   assert_month_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      field_q[47:40] >= 8'h01 && field_q[47:40] <= 8'h12);
   assert_century_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      field_q[63:56] <= 8'h39);
   assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_time & ~USED) == 64'h0);
   assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && stop_bit) |=> $stable(cur_time));
   assert_sec_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> (osc_tick && !stop_bit));
   assert_sec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !sec_tick) |=> $stable(field_q));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
   .clk(clk), .rst_n(rst_n), .load(load), .osc_tick(osc_tick),
   .sec_tick(sec_tick), .stop_bit(stop_q), .field_q(field_q),
   .cur_time(cur_time)
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
   localparam int OSC = 64;
   localparam int THZ = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_tick = 1'b0;
   logic        load = 1'b0;
   logic [63:0] ld_time = '0;
   logic [63:0] cur_time;
   int total = 0;
   int bad = 0;

   bcd_calendar #(.OSC_HZ(OSC), .TEST_HZ(THZ)) uut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .load(load),
      .ld_time(ld_time), .cur_time(cur_time)
   );

   always #5 clk = ~clk;

   function automatic logic [7:0] enc(input int x);
      return 8'((x / 10) * 16 + (x % 10));
   endfunction
   function automatic int dec(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction
   function automatic int mdays(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction
   function automatic logic [63:0] pack(input int s, mi, h, d, dt, mo, y, c);
      return {enc(c), enc(y), enc(mo), enc(dt), enc(d), enc(h), enc(mi), enc(s)};
   endfunction
   // advance a plain count value (no control bits) by one second
   function automatic logic [63:0] next_sec(input logic [63:0] t);
      int s, mi, h, d, dt, mo, y, c;
      s = dec(t[7:0]); mi = dec(t[15:8]); h = dec(t[23:16]); d = dec(t[31:24]);
      dt = dec(t[39:32]); mo = dec(t[47:40]); y = dec(t[55:48]); c = dec(t[63:56]);
      s++;
      if (s > 59) begin
         s = 0; mi++;
         if (mi > 59) begin
            mi = 0; h++;
            if (h > 23) begin
               h = 0;
               d = (d == 7) ? 1 : d + 1;
               dt++;
               if (dt > mdays(mo, y)) begin
                  dt = 1; mo++;
                  if (mo > 12) begin
                     mo = 1; y++;
                     if (y > 99) begin
                        y = 0;
                        c = (c == 39) ? 0 : c + 1;
                     end
                  end
               end
            end
         end
      end
      return pack(s, mi, h, d, dt, mo, y, c);
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_load(input logic [63:0] v);
      load = 1'b1; ld_time = v;
      @(negedge clk);
      load = 1'b0; ld_time = '0;
   endtask

   initial begin
      #2000000;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] t, e;
      run(3);
      rst_n = 1'b1;
      run(1);
      check("R1 reset value", cur_time, 64'h0000010101000000);

      // R2: no advance without osc_tick
      run(200);
      check("R2 idle without osc_tick", cur_time, 64'h0000010101000000);
      osc_tick = 1'b1;
      run(OSC - 1);
      check("R2 one short of a second", cur_time, 64'h0000010101000000);
      run(1);
      check("R2 second advance", cur_time, 64'h0000010101000001);

      // R7/R4: full rollover to century 00, day 7 -> 1
      t = pack(59, 59, 23, 7, 31, 12, 99, 39);
      do_load(t);
      run(OSC);
      check("R7 century wrap", cur_time, pack(0, 0, 0, 1, 1, 1, 0, 0));

      // R6: leap year 00 and non-leap 01
      do_load(pack(59, 59, 23, 2, 28, 2, 0, 20));
      run(OSC);
      check("R6 feb 28 leap", cur_time, pack(0, 0, 0, 3, 29, 2, 0, 20));
      do_load(pack(59, 59, 23, 2, 28, 2, 1, 20));
      run(OSC);
      check("R6 feb 28 common", cur_time, pack(0, 0, 0, 3, 1, 3, 1, 20));

      // R5: 30 and 31 day months
      do_load(pack(59, 59, 23, 4, 30, 4, 15, 20));
      run(OSC);
      check("R5 april end", cur_time, pack(0, 0, 0, 5, 1, 5, 15, 20));
      do_load(pack(59, 59, 23, 4, 30, 1, 15, 20));
      run(OSC);
      check("R5 jan 30", cur_time, pack(0, 0, 0, 5, 31, 1, 15, 20));

      // R4: day of week wraps independent of date
      do_load(pack(59, 59, 23, 7, 5, 6, 33, 3));
      run(OSC);
      check("R4 dow wrap", cur_time, pack(0, 0, 0, 1, 6, 6, 33, 3));

      // R3: minute and hour carries
      do_load(pack(59, 59, 22, 1, 10, 10, 10, 10));
      run(OSC);
      check("R3 hour carry", cur_time, pack(0, 0, 23, 1, 10, 10, 10, 10));

      // R8: halt
      t = pack(30, 12, 5, 2, 3, 4, 5, 6) | 64'h80;
      do_load(t);
      run(3 * OSC);
      check("R8 halted time", cur_time, t);

      // R10: load restarts divider mid-count
      do_load(pack(30, 12, 5, 2, 3, 4, 5, 6));
      run(OSC / 2);
      do_load(pack(40, 12, 5, 2, 3, 4, 5, 6));
      run(OSC - 1);
      check("R10 restart no advance", cur_time, pack(40, 12, 5, 2, 3, 4, 5, 6));
      run(1);
      check("R10 advance after load", cur_time, pack(41, 12, 5, 2, 3, 4, 5, 6));

      // R11: unused bits masked (halted so nothing moves)
      do_load(64'hD2_47_E5_C9_83_C5_B3_80 | pack(0, 0, 0, 0, 0, 0, 0, 0));
      run(2);
      check("R11 masked load", cur_time, 64'h12_47_05_09_03_05_33_80);

      // R9: test bit square wave on seconds LSB
      do_load(pack(19, 1, 1, 2, 1, 1, 1, 1) | 64'h40_00_00_00);
      run(3);
      check("R9 phase start", cur_time[7:0], 8'h18);
      run(1);
      check("R9 phase flip", cur_time[7:0], 8'h19);
      run(4);
      check("R9 phase flip back", cur_time[7:0], 8'h18);
      run(OSC - 8);
      check("R9 count continues", cur_time, pack(20, 1, 1, 2, 1, 1, 1, 1) | 64'h40_00_00_00);
      do_load(pack(19, 1, 1, 2, 1, 1, 1, 1) | 64'h40_00_00_80);
      run(10);
      check("R9 no toggle when halted", cur_time[7:0], 8'h99);

      // random sweep near boundaries (R3 R5 R6 R7)
      void'($urandom(32'h1F2E3D));
      for (int it = 0; it < 40; it++) begin
         int s, mi, h, d, dt, mo, y, c, k;
         s  = 55 + int'($urandom % 5);
         mi = ($urandom % 2) ? 59 : int'($urandom % 60);
         h  = ($urandom % 2) ? 23 : int'($urandom % 24);
         d  = 1 + int'($urandom % 7);
         mo = 1 + int'($urandom % 12);
         y  = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
         c  = ($urandom % 4 == 0) ? 39 : int'($urandom % 40);
         dt = ($urandom % 2) ? mdays(mo, y) : 1 + int'($urandom % mdays(mo, y));
         k  = 1 + int'($urandom % 3);
         t = pack(s, mi, h, d, dt, mo, y, c);
         do_load(t);
         run(k * OSC);
         e = t;
         for (int j = 0; j < k; j++) e = next_sec(e);
         check("R3 R5 R6 R7 random step", cur_time, e);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule